// File: doc/BRIEF.md
# Cyclic Wake Input Sampler

This block watches two external wake pins and turns their level changes into sticky wake interrupt flags. Each pin can be followed in one of two ways. In the first, the pin is synchronised and sampled on every clock. In the second, the pin is sampled only at the moment a generated bias pulse starts. The bias pulse drives an external enable that powers the wake switches for a short time, so the switches draw current only in that window. A 1 ms tick from outside times the bias pulse. The pulse repeats every 16 or 64 ticks and stays high for one tick.

Each pin has a two-bit trigger field that selects rising edges, falling edges, both, or nothing. A detected event sets the pin's sticky flag. If the power-mode state is Sleep when the event happens, the state returns to Standby. Software reaches the block through a flat parallel port: a write strobe with address and data, and a combinational read path.

Top module: `wake_sampler_top`

## Requirements
- R1: `bias_o` goes high on the clock edge at which a tick arrives with the period counter at zero. It falls on the following tick. Rising edges of `bias_o` are 16 ticks apart when the period-select bit (address 0, bit 6) is 0 and 64 ticks apart when it is 1. The first pulse after reset starts on the first tick.
- R2: With the pin's sync-mode bit at 0 (address 0, bit 4 for pin 0, bit 5 for pin 1), a pin level change reaches the sampled level on the third rising clock edge after it is applied. Two edges are spent in the synchroniser and one in the sample register.
- R3: With the pin's sync-mode bit at 1, the sampled level changes only on the clock edge at which `bias_o` rises. Pin changes between bias pulses leave the level status unchanged.
- R4: Each pin has a trigger field: pin 0 at address 0 bits 1:0, pin 1 at address 0 bits 3:2. The codes are 00 none, 01 rising, 10 falling, 11 both. An event is a change of the sampled level in a direction the field selects.
- R5: A pin's wake flag (`wake_irq_o[i]`, also address 2 bit i) is set on the same edge as its event and stays set. Writing 1 to address 2 bit i clears it. An event in the same cycle as a clear leaves the flag set.
- R6: The level status bits (address 2 bit 2 for pin 0, bit 3 for pin 1) show the sampled levels only while at least one trigger field is nonzero. Otherwise they read 0.
- R7: Address 1 bit 0 holds the mode state, with 1 for Sleep and 0 for Standby, and is written there. A wake event while in Sleep returns the state to Standby on the event's edge. The event wins over a write in the same cycle. `sleep_o` shows the state.
- R8: After reset both trigger fields are 00, both sync-mode bits are 0, the period select is 0 (16 ticks), the mode is Standby, the flags and sampled levels are 0, and `bias_o` is low.
- R9: Reads are combinational. Address 0 returns {0, period select, sync1, sync0, trig1, trig0}. Address 1 returns the mode bit. Address 2 returns {0000, level1, level0, flag1, flag0}. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe once per millisecond |
| wake_i | input | 2 | Asynchronous wake pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| bias_o | output | 1 | Bias enable pulse for the external wake switches |
| wake_irq_o | output | 2 | Sticky wake interrupt flags |
| sleep_o | output | 1 | High while the mode state is Sleep |

## Verification
The assertions check several rules on every cycle. The bias pulse rises only on a tick and holds between ticks. A pin in sync mode keeps its sampled level unless a capture strobe comes. A flag drops only after a clear. A new flag needs a nonzero trigger field. Sleep ends only through a wake event or a write.

Some behaviour can be shown only by the bench's scenarios, which compare the design against a behavioural model on every clock. These cover the exact three-edge latency in continuous mode and the 16- and 64-tick spacing of the pulses. They also cover the event-over-clear collision, the gating of the level status, and the return from Sleep.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int NUM_WAKE = 2;
   localparam int DATA_W   = 8;
   localparam int ADDR_W   = 2;

   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

   typedef enum logic [1:0] {
      TRIG_NONE = 2'b00,
      TRIG_RISE = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_BOTH = 2'b11
   } trig_e;

   typedef enum logic {
      MODE_STANDBY = 1'b0,
      MODE_SLEEP   = 1'b1
   } pmode_e;
endpackage

// File: rtl/wake_bias_timer.sv
module wake_bias_timer #(
   parameter int SHORT_TICKS = 16,
   parameter int LONG_TICKS  = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic long_sel_i,
   output logic bias_o,
   output logic cap_o
);
   localparam int CNT_W = (LONG_TICKS > 1) ? $clog2(LONG_TICKS) : 1;
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last  = long_sel_i ? LONG_LAST : SHORT_LAST;
   assign cap_o = tick_i && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bias_o <= 1'b0;
      end else if (tick_i) begin
         bias_o <= (cnt_q == '0);
         cnt_q  <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
      end
   end

   // R1
   bias_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bias_o) |-> $past(tick_i));
   // R1
   bias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(bias_o));
endmodule

// File: rtl/wake_chan.sv
module wake_chan #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic       sync_mode_i,
   input  logic       cap_i,
   input  logic [1:0] trig_i,
   input  logic       clr_i,
   output logic       level_o,
   output logic       event_o,
   output logic       flag_o
);
   logic [SYNC_STAGES-1:0] sh_q;
   logic synced, upd, chg, rise, fall;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh_q <= '0;
            else        sh_q <= pin_i;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], pin_i};
      end
   endgenerate

   assign synced  = sh_q[SYNC_STAGES-1];
   assign upd     = sync_mode_i ? cap_i : 1'b1;
   assign chg     = upd && (synced != level_o);
   assign rise    = chg && synced;
   assign fall    = chg && !synced;
   assign event_o = (trig_i[0] && rise) || (trig_i[1] && fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= 1'b0;
         flag_o  <= 1'b0;
      end else begin
         if (upd)          level_o <= synced;
         if (event_o)      flag_o  <= 1'b1;
         else if (clr_i)   flag_o  <= 1'b0;
      end
   end

   // R3
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode_i && !cap_i) |=> $stable(level_o));
   // R5
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(clr_i));
   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(trig_i != 2'b00));
endmodule

// File: rtl/wake_sampler_top.sv
module wake_sampler_top
   import wake_pkg::*;
#(
   parameter int SHORT_TICKS = 16,
   parameter int LONG_TICKS  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [1:0]        wake_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [1:0]        rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              bias_o,
   output logic [1:0]        wake_irq_o,
   output logic              sleep_o
);
   generate
      if (SHORT_TICKS < 2 || LONG_TICKS <= SHORT_TICKS) begin : g_bad_period
         $error("wake_sampler_top: need 2 <= SHORT_TICKS < LONG_TICKS");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("wake_sampler_top: SYNC_STAGES must be at least 1");
      end
   endgenerate

   trig_e   trig_q [NUM_WAKE];
   logic [NUM_WAKE-1:0] syncm_q;
   logic    long_q;
   pmode_e  mode_q;

   logic [NUM_WAKE-1:0] level, evt, clr;
   logic [NUM_WAKE-1:0] stat_lvl;
   logic cap, any_evt, any_trig;
   logic wr_ctrl, wr_mode, wr_stat;

   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
   assign wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);
   assign wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);

   wake_bias_timer #(
      .SHORT_TICKS(SHORT_TICKS),
      .LONG_TICKS (LONG_TICKS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .long_sel_i(long_q),
      .bias_o    (bias_o),
      .cap_o     (cap)
   );

   for (genvar i = 0; i < NUM_WAKE; i++) begin : g_chan
      assign clr[i] = wr_stat && wr_data_i[i];
      wake_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_i      (wake_i[i]),
         .sync_mode_i(syncm_q[i]),
         .cap_i      (cap),
         .trig_i     (trig_q[i]),
         .clr_i      (clr[i]),
         .level_o    (level[i]),
         .event_o    (evt[i]),
         .flag_o     (wake_irq_o[i])
      );
   end

   assign any_evt  = |evt;
   assign any_trig = (trig_q[0] != TRIG_NONE) || (trig_q[1] != TRIG_NONE);
   assign stat_lvl = any_trig ? level : '0;
   assign sleep_o  = (mode_q == MODE_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q[0] <= TRIG_NONE;
         trig_q[1] <= TRIG_NONE;
         syncm_q   <= '0;
         long_q    <= 1'b0;
         mode_q    <= MODE_STANDBY;
      end else begin
         if (wr_ctrl) begin
            trig_q[0] <= trig_e'(wr_data_i[1:0]);
            trig_q[1] <= trig_e'(wr_data_i[3:2]);
            syncm_q   <= wr_data_i[5:4];
            long_q    <= wr_data_i[6];
         end
         if (any_evt && mode_q == MODE_SLEEP) mode_q <= MODE_STANDBY;
         else if (wr_mode)                    mode_q <= pmode_e'(wr_data_i[0]);
      end
   end

   always_comb begin
      case (rd_addr_i)
         ADDR_CTRL: rd_data_o = {1'b0, long_q, syncm_q, trig_q[1], trig_q[0]};
         ADDR_MODE: rd_data_o = {7'b0, sleep_o};
         ADDR_STAT: rd_data_o = {4'b0, stat_lvl, wake_irq_o};
         default:   rd_data_o = '0;
      endcase
   end

   // R7
   sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_o) |-> ($past(any_evt) || $past(wr_mode && !wr_data_i[0])));
   // R7
   sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_evt && sleep_o) |=> !sleep_o);
endmodule

// File: tb/sim_wake_sampler_top.sv
`timescale 1ns/1ps
module sim_wake_sampler_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] wake_i = 2'b00;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_addr_i = 2'd0;
   logic [7:0] wr_data_i = 8'd0;
   logic [1:0] rd_addr_i = 2'd0;
   logic [7:0] rd_data_o;
   logic       bias_o;
   logic [1:0] wake_irq_o;
   logic       sleep_o;

   localparam int TICK_DIV = 4;

   wake_sampler_top u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wake_i(wake_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .bias_o(bias_o),
      .wake_irq_o(wake_irq_o), .sleep_o(sleep_o)
   );

   always #5 clk = ~clk;

   int total = 0;
   int fails = 0;
   int cyc   = 0;
   bit done  = 0;
   bit blast = 0;
   bit rose_now = 0;

   // behavioural reference state
   int mcnt;
   bit mbias, mlong, msleep;
   bit [1:0] mcfg [2];
   bit [1:0] msync, ms1, ms2, mlvl, mflag;

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic bit [7:0] model_rd(bit [1:0] a);
      bit [1:0] lv;
      lv = (mcfg[0] != 0 || mcfg[1] != 0) ? mlvl : 2'b00;
      case (a)
         2'd0: return {1'b0, mlong, msync[1], msync[0], mcfg[1], mcfg[0]};
         2'd1: return {7'b0, msleep};
         2'd2: return {4'b0, lv, mflag};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mcnt = 0; mbias = 0; mlong = 0; msleep = 0;
         mcfg[0] = 0; mcfg[1] = 0; msync = 0; ms1 = 0; ms2 = 0; mlvl = 0; mflag = 0;
      end else begin
         bit cap, anyev;
         cap = tick_i && (mcnt == 0);
         if (tick_i) begin
            mbias = (mcnt == 0);
            mcnt  = (mcnt >= (mlong ? 64 : 16) - 1) ? 0 : mcnt + 1;
         end
         anyev = 0;
         for (int i = 0; i < 2; i++) begin
            bit take, ev;
            take = msync[i] ? cap : 1'b1;
            ev = 0;
            if (take && ms2[i] != mlvl[i]) begin
               if (ms2[i] && mcfg[i][0])  ev = 1;
               if (!ms2[i] && mcfg[i][1]) ev = 1;
               mlvl[i] = ms2[i];
            end
            if (ev) mflag[i] = 1;
            else if (wr_en_i && wr_addr_i == 2'd2 && wr_data_i[i]) mflag[i] = 0;
            anyev |= ev;
            ms2[i] = ms1[i];
            ms1[i] = wake_i[i];
         end
         if (wr_en_i && wr_addr_i == 2'd0) begin
            mcfg[0] = wr_data_i[1:0];
            mcfg[1] = wr_data_i[3:2];
            msync   = wr_data_i[5:4];
            mlong   = wr_data_i[6];
         end
         if (anyev && msleep) msleep = 0;
         else if (wr_en_i && wr_addr_i == 2'd1) msleep = wr_data_i[0];
      end
   end

   // one cycle: wait for the falling edge, compare everything, set the next tick
   task automatic step();
      @(negedge clk);
      cyc++;
      rose_now = bias_o && !blast;
      blast = bias_o;
      if (rst_n) begin
         chk(bias_o == mbias, "R1 bias", bias_o, mbias);
         chk(wake_irq_o == mflag, "R5 flags", wake_irq_o, mflag);
         chk(sleep_o == msleep, "R7 mode", sleep_o, msleep);
         chk(rd_data_o == model_rd(rd_addr_i), "R9 read", rd_data_o, model_rd(rd_addr_i));
         rd_addr_i = rd_addr_i + 2'd1;
      end
      tick_i = (cyc % TICK_DIV) == 0;
   endtask

   task automatic wr(bit [1:0] a, bit [7:0] d);
      wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
      step();
      wr_en_i = 0;
   endtask

   task automatic rd(bit [1:0] a, output bit [7:0] d);
      rd_addr_i = a;
      #1;
      d = rd_data_o;
   endtask

   task automatic wait_rise(output int c);
      do step(); while (!rose_now);
      c = cyc;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      bit [7:0] d;
      int c0, c1;
      repeat (3) step();
      rst_n = 1;
      // R8 reset state
      rd(2'd0, d); chk(d == 8'h00, "R8 ctrl reset", d, 0);
      rd(2'd1, d); chk(d == 8'h00, "R8 mode reset", d, 0);
      rd(2'd2, d); chk(d == 8'h00, "R8 status reset", d, 0);
      chk(bias_o == 0, "R8 bias reset", bias_o, 0);

      // R2/R4: continuous, pin0 rising, pin1 falling
      wr(2'd0, 8'b0000_1001);
      wake_i = 2'b11;
      step(); step();
      rd(2'd2, d); chk(d[0] == 0, "R2 not yet sampled", d[0], 0);
      step();
      rd(2'd2, d); chk(d[0] == 1 && d[2] == 1, "R2 R4 rise after 3 edges", d, 8'h0d);
      chk(wake_irq_o[1] == 0, "R4 rise ignored by falling field", wake_irq_o[1], 0);
      wake_i = 2'b00;
      repeat (4) step();
      chk(wake_irq_o == 2'b11, "R4 fall flags pin1", wake_irq_o, 3);

      // R5 clear and collision
      wr(2'd2, 8'h03);
      chk(wake_irq_o == 2'b00, "R5 cleared", wake_irq_o, 0);
      wake_i = 2'b01;
      step(); step();
      wr(2'd2, 8'h01);
      chk(wake_irq_o[0] == 1, "R5 event beats clear", wake_irq_o[0], 1);
      wr(2'd2, 8'h01);
      chk(wake_irq_o[0] == 0, "R5 clear alone", wake_irq_o[0], 0);

      // R6 gating with both fields off
      wr(2'd0, 8'h00);
      rd(2'd2, d); chk(d[3:2] == 2'b00, "R6 level gated off", d[3:2], 0);
      wake_i = 2'b10;
      repeat (5) step();
      rd(2'd2, d); chk(d == 8'h00, "R6 disabled no flag, no level", d, 0);
      wr(2'd0, 8'b0000_0100);
      rd(2'd2, d); chk(d[3:2] == 2'b10, "R6 level shown when any field set", d[3:2], 2);

      // R3 sync mode, 16-tick period, both edges
      wr(2'd0, 8'b0011_1111);
      wait_rise(c0);
      rd(2'd2, d); c1 = d[3:2];
      wake_i = 2'b01;
      repeat (20) step();
      rd(2'd2, d); chk(d[3:2] == c1[1:0], "R3 held between pulses", d[3:2], c1);
      wait_rise(c1);
      rd(2'd2, d); chk(d[3:2] == 2'b01, "R3 captured on bias rise", d[3:2], 1);
      chk(c1 - c0 == 16 * TICK_DIV, "R1 short period", c1 - c0, 16 * TICK_DIV);

      // R1 long period
      wr(2'd0, 8'b0111_1111);
      wait_rise(c0);
      wait_rise(c0);
      wait_rise(c1);
      chk(c1 - c0 == 64 * TICK_DIV, "R1 long period", c1 - c0, 64 * TICK_DIV);

      // R7 sleep and wake, continuous, both edges
      wr(2'd0, 8'b0000_1111);
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h01);
      chk(sleep_o == 1, "R7 sleep written", sleep_o, 1);
      repeat (5) step();
      chk(sleep_o == 1, "R7 stays asleep", sleep_o, 1);
      wake_i = 2'b11;
      step(); step(); step();
      chk(sleep_o == 0, "R7 woken by event", sleep_o, 0);
      wr(2'd1, 8'h01);
      wake_i = 2'b00;
      step(); step();
      wr(2'd1, 8'h01);
      chk(sleep_o == 0, "R7 event beats write", sleep_o, 0);
      repeat (10) step();

      done = 1;
      summary();
   end
endmodule